// File: doc/BRIEF.md
# Banked APB Interrupt Combiner

This block gathers a configurable number of level-sensitive interrupt lines, from 2 up to 64, and merges them into one active-high request for a parent interrupt controller. Each source is gated by its own enable bit and its own mask bit. Sources that pass both gates show up in a read-only status view, and any set status bit drives the merged request.

Software reaches the block through an APB slave port. Each kind of register comes as a pair of 32-bit words. The lower word covers sources 0 to 31, and the upper word covers sources 32 to 63. Storage exists only for the sources that are actually built. Software can therefore write all ones to the enable words and count the ones that read back to learn the configured source count.

Top module: `apb_irq_combiner`

## Requirements
- R1: Enable words: byte offset 0x00 holds the enable bit for source n at bit n (n = 0..31), and offset 0x04 holds the enable bit for source n at bit n-32 (n = 32..63). A write sets the whole word.
- R2: Mask words: offset 0x08 covers sources 0..31 and offset 0x0C covers sources 32..63, with the same bit mapping as R1. A mask bit of 1 stops its source from reaching status and the request.
- R3: Status words at offset 0x30 (sources 0..31) and 0x34 (sources 32..63) read raw input AND enable AND NOT mask for each source. Writes to these offsets change nothing.
- R4: The parameter NUM_SRC sets the source count (2..64). Enable and mask bits at positions NUM_SRC and above are not stored and always read 0, so writing all ones to both enable words reads back exactly NUM_SRC ones.
- R5: When NUM_SRC is 32 or less, every register at offsets 0x04, 0x0C and 0x34 reads as zero.
- R6: irq_out is a registered OR of all status bits. It rises on the clock edge after any status bit becomes 1 and falls on the edge after all status bits are 0.
- R7: A synchronous active-high reset clears all enable and mask bits and drives irq_out low.
- R8: Reads of any word offset other than the six listed above return zero, and writes to such offsets change no register. Address bits [1:0] are ignored.
- R9: pready is always 1. A write takes effect at the clock edge where psel, penable and pwrite are all high. prdata is valid during the access phase of a read and is zero when no read is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |
| irq_src | input | NUM_SRC | Level-sensitive interrupt inputs, bit n is source n |
| irq_out | output | 1 | Merged interrupt request, active high |

## Verification
If an enable or mask flop holds a wrong value, it shows up on the next read of its word. It also shows up in the status word and on irq_out one edge after the matching input is driven. A flop that should not exist but does is caught by the all-ones probe, which finds a source count different from NUM_SRC. A wrong bank or bit mapping is caught by walking a single active input across every source and checking which status bit lights up. A stuck or unregistered request line is caught by sampling irq_out both just before and just after the edge that should change it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_BITS = 32;
    localparam int MAX_BANKS = 2;

    // word indices (byte offset / 4); the bank bit of each pair is bit 0
    localparam logic [29:0] W_EN_LO   = 30'h00;
    localparam logic [29:0] W_EN_HI   = 30'h01;
    localparam logic [29:0] W_MASK_LO = 30'h02;
    localparam logic [29:0] W_MASK_HI = 30'h03;
    localparam logic [29:0] W_STAT_LO = 30'h0C;
    localparam logic [29:0] W_STAT_HI = 30'h0D;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_EN,
        RK_MASK,
        RK_STAT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic      hi;
    } reg_sel_t;

    function automatic reg_sel_t decode_word(input logic [29:0] word);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.hi   = 1'b0;
        case (word)
            W_EN_LO:   begin s.kind = RK_EN;   s.hi = 1'b0; end
            W_EN_HI:   begin s.kind = RK_EN;   s.hi = 1'b1; end
            W_MASK_LO: begin s.kind = RK_MASK; s.hi = 1'b0; end
            W_MASK_HI: begin s.kind = RK_MASK; s.hi = 1'b1; end
            W_STAT_LO: begin s.kind = RK_STAT; s.hi = 1'b0; end
            W_STAT_HI: begin s.kind = RK_STAT; s.hi = 1'b1; end
            default:   begin s.kind = RK_NONE; s.hi = 1'b0; end
        endcase
        return s;
    endfunction

    // number of implemented sources that land in a bank
    function automatic int bank_width(input int nsrc, input int bank);
        int r;
        r = nsrc - BANK_BITS * bank;
        if (r < 0)
            r = 0;
        if (r > BANK_BITS)
            r = BANK_BITS;
        return r;
    endfunction

    // bit mask of implemented positions within a bank word
    function automatic logic [31:0] bank_valid(input int nsrc, input int bank);
        int w;
        w = bank_width(nsrc, bank);
        if (w >= BANK_BITS)
            return '1;
        if (w <= 0)
            return '0;
        return (32'd1 << w) - 32'd1;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_mask,
    input  logic [31:0]      wdata,
    input  logic [WIDTH-1:0] src,
    output logic [31:0]      en_q,
    output logic [31:0]      mask_q,
    output logic [31:0]      fstat
);

    logic [WIDTH-1:0] en_r;
    logic [WIDTH-1:0] mask_r;
    logic [WIDTH-1:0] pass_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r   <= '0;
            mask_r <= '0;
        end else begin
            if (wr_en)
                en_r <= wdata[WIDTH-1:0];
            if (wr_mask)
                mask_r <= wdata[WIDTH-1:0];
        end
    end

    assign pass_w = src & en_r & ~mask_r;

    generate
        if (WIDTH < 32) begin : g_pad
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata[31:WIDTH];
            assign en_q   = {{(32-WIDTH){1'b0}}, en_r};
            assign mask_q = {{(32-WIDTH){1'b0}}, mask_r};
            assign fstat  = {{(32-WIDTH){1'b0}}, pass_w};
        end else begin : g_full
            assign en_q   = en_r;
            assign mask_q = mask_r;
            assign fstat  = pass_w;
        end
    endgenerate

endmodule

// File: rtl/irqc_apb_port.sv
module irqc_apb_port
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [1:0][31:0]  en_q,
    input  logic [1:0][31:0]  mask_q,
    input  logic [1:0][31:0]  stat_q,
    output logic [1:0]        wr_en,
    output logic [1:0]        wr_mask,
    output logic [31:0]       prdata,
    output logic              pready
);

    reg_sel_t sel;
    logic     commit;
    logic     rd_act;
    logic     unused_lsb;

    assign unused_lsb = ^paddr[1:0];
    assign sel        = decode_word(30'(paddr[ADDR_W-1:2]));
    assign commit     = psel & penable & pwrite;
    assign rd_act     = psel & ~pwrite;
    assign pready     = 1'b1;

    always_comb begin
        wr_en   = '0;
        wr_mask = '0;
        if (commit) begin
            case (sel.kind)
                RK_EN:   wr_en[sel.hi]   = 1'b1;
                RK_MASK: wr_mask[sel.hi] = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_act) begin
            case (sel.kind)
                RK_EN:   prdata = en_q[sel.hi];
                RK_MASK: prdata = mask_q[sel.hi];
                RK_STAT: prdata = stat_q[sel.hi];
                default: prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0][31:0] stat_q,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= |stat_q;
    end

endmodule

// File: rtl/apb_irq_combiner.sv
module apb_irq_combiner
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);

    logic [1:0][31:0] en_q;
    logic [1:0][31:0] mask_q;
    logic [1:0][31:0] stat_q;
    logic [1:0]       wr_en;
    logic [1:0]       wr_mask;

    generate
        for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
            localparam int W = bank_width(NUM_SRC, b);
            if (W > 0) begin : g_on
                irqc_bank #(
                    .WIDTH (W)
                ) u_bank (
                    .clk     (clk),
                    .rst     (rst),
                    .wr_en   (wr_en[b]),
                    .wr_mask (wr_mask[b]),
                    .wdata   (pwdata),
                    .src     (irq_src[b*BANK_BITS +: W]),
                    .en_q    (en_q[b]),
                    .mask_q  (mask_q[b]),
                    .fstat   (stat_q[b])
                );
            end else begin : g_off
                logic unused_strobe;
                assign unused_strobe = wr_en[b] ^ wr_mask[b];
                assign en_q[b]   = '0;
                assign mask_q[b] = '0;
                assign stat_q[b] = '0;
            end
        end
    endgenerate

    irqc_apb_port #(
        .ADDR_W (ADDR_W)
    ) u_port (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .en_q    (en_q),
        .mask_q  (mask_q),
        .stat_q  (stat_q),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .prdata  (prdata),
        .pready  (pready)
    );

    irqc_irq_out u_out (
        .clk    (clk),
        .rst    (rst),
        .stat_q (stat_q),
        .irq    (irq_out)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        prdata,
    input logic               pready,
    input logic [NUM_SRC-1:0] irq_src,
    input logic               irq_out,
    input logic [31:0]        stat_lo,
    input logic [31:0]        stat_hi
);

    localparam logic [31:0] VALID_LO = bank_valid(NUM_SRC, 0);
    localparam logic [31:0] VALID_HI = bank_valid(NUM_SRC, 1);
    localparam logic        SMALL    = (NUM_SRC <= 32);

    reg_sel_t    sel;
    logic        rd_act;
    logic [31:0] valid_w;

    assign sel     = decode_word(30'(paddr[ADDR_W-1:2]));
    assign rd_act  = psel & ~pwrite;
    assign valid_w = sel.hi ? VALID_HI : VALID_LO;

    assert_pready_R9: assert property (@(posedge clk) disable iff (rst)
        pready == 1'b1);

    assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_act && sel.kind != RK_NONE) |-> ((prdata & ~valid_w) == 32'd0));

    assert_hi_bank_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (SMALL && rd_act && sel.hi) |-> (prdata == 32'd0));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_act && sel.kind == RK_NONE) |-> (prdata == 32'd0));

    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (|{stat_hi, stat_lo}) |=> irq_out);

    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
        !(|{stat_hi, stat_lo}) |=> !irq_out);

    assert_no_input_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_src == '0) |=> !irq_out);

    assert_reset_quiet_R7: assert property (@(posedge clk)
        rst |=> !irq_out);

endmodule

bind apb_irq_combiner irqc_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .pready  (pready),
    .irq_src (irq_src),
    .irq_out (irq_out),
    .stat_lo (stat_q[0]),
    .stat_hi (stat_q[1])
);

// File: tb/sim_apb_irq_combiner.sv
`timescale 1ns/1ps
module sim_apb_irq_combiner;

    localparam int NA = 40;
    localparam int NB = 20;
    localparam logic [63:0] IMP_A = (64'd1 << NA) - 64'd1;
    localparam logic [63:0] IMP_B = (64'd1 << NB) - 64'd1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [NA-1:0] src_a;
    logic [31:0] prd_a, prd_b;
    logic        rdy_a, rdy_b, irq_a, irq_b;

    apb_irq_combiner #(.NUM_SRC(NA), .ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd_a), .pready(rdy_a),
        .irq_src(src_a), .irq_out(irq_a));

    apb_irq_combiner #(.NUM_SRC(NB), .ADDR_W(12)) u1 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd_b), .pready(rdy_b),
        .irq_src(src_a[NB-1:0]), .irq_out(irq_b));

    int vectors = 0;
    int errs = 0;
    logic done = 1'b0;
    logic [63:0] en_a, mk_a, en_b, mk_b;
    logic [31:0] rd_a, rd_b;

    function automatic logic [63:0] stat_a();
        return 64'(src_a) & en_a & ~mk_a;
    endfunction

    function automatic logic [63:0] stat_b();
        return 64'(src_a) & IMP_B & en_b & ~mk_b;
    endfunction

    function automatic logic [31:0] exp_reg(input logic [11:0] a, input logic [63:0] en,
                                            input logic [63:0] mk, input logic [63:0] st);
        case (a)
            12'h000: return en[31:0];
            12'h004: return en[63:32];
            12'h008: return mk[31:0];
            12'h00C: return mk[63:32];
            12'h030: return st[31:0];
            12'h034: return st[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h000: begin en_a[31:0]  = d & IMP_A[31:0];  en_b[31:0]  = d & IMP_B[31:0];  end
            12'h004: begin en_a[63:32] = d & IMP_A[63:32]; en_b[63:32] = d & IMP_B[63:32]; end
            12'h008: begin mk_a[31:0]  = d & IMP_A[31:0];  mk_b[31:0]  = d & IMP_B[31:0];  end
            12'h00C: begin mk_a[63:32] = d & IMP_A[63:32]; mk_b[63:32] = d & IMP_B[63:32]; end
            default: ;
        endcase
        bus_wr(a, d);
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd_a = prd_a;
        rd_b = prd_b;
        chk("R9", "pready", {31'd0, rdy_a & rdy_b}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        rd(a);
        chk(req, $sformatf("u0 read %h", a), rd_a, exp_reg(a, en_a, mk_a, stat_a()));
        chk(req, $sformatf("u1 read %h", a), rd_b, exp_reg(a, en_b, mk_b, stat_b()));
    endtask

    task automatic irq_chk(input string req);
        chk(req, "u0 irq_out", {31'd0, irq_a}, {31'd0, |stat_a()});
        chk(req, "u1 irq_out", {31'd0, irq_b}, {31'd0, |stat_b()});
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        int ca, cb;
        rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; src_a = '0;
        en_a = '0; mk_a = '0; en_b = '0; mk_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        rd_chk("R7", 12'h000); rd_chk("R7", 12'h004);
        rd_chk("R7", 12'h008); rd_chk("R7", 12'h00C);
        irq_chk("R7");

        // R4 / R1: probe source count through enable words
        wr(12'h000, '1); wr(12'h004, '1);
        rd(12'h000); ca = $countones(rd_a); cb = $countones(rd_b);
        rd(12'h004); ca += $countones(rd_a); cb += $countones(rd_b);
        chk("R5", "u1 enable high word", rd_b, 32'd0);
        chk("R4", "u0 enable count", 32'(ca), 32'(NA));
        chk("R4", "u1 enable count", 32'(cb), 32'(NB));
        rd_chk("R1", 12'h000); rd_chk("R1", 12'h004);

        // R2 / R4: mask words hold only implemented bits
        wr(12'h008, '1); wr(12'h00C, '1);
        rd(12'h008); ca = $countones(rd_a); cb = $countones(rd_b);
        rd(12'h00C); ca += $countones(rd_a); cb += $countones(rd_b);
        chk("R5", "u1 mask high word", rd_b, 32'd0);
        chk("R4", "u0 mask count", 32'(ca), 32'(NA));
        chk("R4", "u1 mask count", 32'(cb), 32'(NB));
        wr(12'h008, 32'd0); wr(12'h00C, 32'd0);

        // R8: unmapped offsets
        wr(12'h010, '1); wr(12'h038, '1); wr(12'h02C, '1); wr(12'h3FC, '1);
        rd_chk("R8", 12'h010); rd_chk("R8", 12'h038);
        rd_chk("R8", 12'h02C); rd_chk("R8", 12'h3FC);
        rd_chk("R8", 12'h000); rd_chk("R8", 12'h004);
        rd_chk("R8", 12'h008); rd_chk("R8", 12'h00C);
        // R8: low address bits ignored
        rd(12'h003);
        chk("R8", "u0 read 003", rd_a, en_a[31:0]);

        // R3: status is read-only
        src_a = 40'hA5_5A5A_F00F;
        wr(12'h030, 32'd0); wr(12'h034, 32'd0);
        rd_chk("R3", 12'h030); rd_chk("R3", 12'h034);
        rd_chk("R3", 12'h000); rd_chk("R3", 12'h004);
        irq_chk("R6");

        // R1 / R2 / R6: walk one active source over every position
        for (int i = 0; i < NA; i++) begin
            logic [11:0] st_off, mk_off;
            st_off = (i < 32) ? 12'h030 : 12'h034;
            mk_off = (i < 32) ? 12'h008 : 12'h00C;
            @(negedge clk);
            src_a = '0;
            settle();
            chk("R6", "irq low with no source", {31'd0, irq_a}, 32'd0);
            src_a = NA'(1) << i;
            #1;
            chk("R6", "irq not yet raised", {31'd0, irq_a}, 32'd0);
            settle();
            chk("R6", "irq raised one edge later", {31'd0, irq_a}, 32'd1);
            irq_chk("R6");
            rd_chk("R1", st_off);
            wr(mk_off, 32'd1 << (i % 32));
            settle();
            rd_chk("R2", st_off);
            irq_chk("R2");
            wr(mk_off, 32'd0);
        end

        // R3 / R6: random patterns of inputs, enables and masks
        for (int k = 0; k < 200; k++) begin
            wr(12'h000, $urandom); wr(12'h004, $urandom);
            wr(12'h008, $urandom & $urandom); wr(12'h00C, $urandom & $urandom);
            @(negedge clk);
            src_a = {$urandom, $urandom};
            settle();
            irq_chk("R6");
            rd_chk("R3", 12'h030); rd_chk("R3", 12'h034);
            rd_chk("R1", 12'h000); rd_chk("R2", 12'h00C);
        end

        // R7: reset in the middle of activity
        wr(12'h000, '1); wr(12'h004, '1);
        @(negedge clk);
        src_a = '1;
        rst = 1'b1;
        settle();
        settle();
        rst = 1'b0;
        en_a = '0; mk_a = '0; en_b = '0; mk_b = '0;
        irq_chk("R7");
        rd_chk("R7", 12'h000); rd_chk("R7", 12'h004);
        rd_chk("R7", 12'h030);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule